// File: doc/BRIEF.md
# Serial Port Status and Error Flags

This block holds the status register of an asynchronous serial port. Four kinds of input reach it. The transmit datapath sends a pulse when the CPU writes transmit data and a pulse when a transfer finishes with nothing queued behind it. The receive datapath sends a frame-complete pulse, which carries a parity-mismatch qualifier and a missing-stop-bit qualifier. The block also takes the power, transmitter-enable and receiver-enable controls, and a small synchronous register port for the CPU.

From these inputs the block keeps a transfer-busy flag and three sticky error flags: parity, framing and overrun. It also keeps a one-entry receive-buffer occupancy bit. With that bit it decides, in the same cycle, whether each newly completed frame may be loaded into the receive buffer. When the buffer still holds an unread frame, the new frame is refused and the overrun flag is raised.

Top module: `uart_stat_flags`

## Requirements
- R1: After reset the status register reads 0x00. Its layout is: bit 7 transfer-busy, bit 2 parity error, bit 1 framing error, bit 0 overrun. Bits 6..3 always read 0. `reg_rdata_o` shows the register when `reg_addr_i` equals `STAT_ADDR` (default 4) and 0 at any other address.
- R2: While power and transmitter are both enabled, a `tx_wr_i` pulse sets transfer-busy. The new value is visible in the next cycle.
- R3: Transfer-busy clears one cycle after `tx_done_idle_i`. It is held clear while power or the transmitter is off. Across back-to-back writes it stays 1, and a write arriving in the same cycle as `tx_done_idle_i` leaves it set.
- R4: A frame with `rx_par_err_i` high sets the parity flag only when `par_chk_en_i` is high.
- R5: A frame with `rx_stop_miss_i` high sets the framing flag.
- R6: A frame that arrives while the buffer is full and no buffer read is present sets the overrun flag. That frame is not loaded (`rx_buf_load_o` low), and the buffer stays full.
- R7: A buffer read (`rx_buf_rd_i`) in the same cycle as a frame frees the buffer first. The frame is then loaded and no overrun is flagged. A read without a frame marks the buffer empty.
- R8: A register write of 0 to an error bit clears that bit. Writing 1 leaves the bit unchanged and never sets it. Writes to any other address have no effect.
- R9: When a hardware set and a software clear hit the same error flag in one cycle, the flag ends up set.
- R10: While power or the receiver is off, the three error flags and the buffer-full state are held at 0, and receive events are ignored.
- R11: `rx_buf_load_o` is combinational in the frame cycle. `rx_buf_full_o` rises one cycle after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_en_i | input | 1 | Port power enable |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| par_chk_en_i | input | 1 | Parity checking configured |
| tx_wr_i | input | 1 | CPU wrote transmit data |
| tx_done_idle_i | input | 1 | Transfer finished, no data pending |
| rx_frame_i | input | 1 | Receive frame complete |
| rx_par_err_i | input | 1 | Parity mismatch on this frame |
| rx_stop_miss_i | input | 1 | First stop bit missing on this frame |
| rx_buf_rd_i | input | 1 | CPU read of receive buffer |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| rx_buf_load_o | output | 1 | Load the current frame into the buffer |
| rx_buf_full_o | output | 1 | Receive buffer holds unread data |

## Verification
Flag and occupancy updates land one edge after the stimulus cycle. Read data is combinational from the current address and the registered state. The load decision is combinational in the frame cycle itself. The bench drives each stimulus cycle after a rising edge. At the following falling edge it compares the load output against a behavioural model evaluated on that cycle's inputs, and compares the read data and the full flag against the model state left by the previous edge. After the next rising edge it advances the model, so every result is sampled in exactly the cycle it becomes due.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int TSF_BIT = 7;
  localparam int N_ERR   = 3;
  // error flag index equals its register bit
  localparam int OVR_IDX = 0;
  localparam int FRM_IDX = 1;
  localparam int PAR_IDX = 2;
  localparam int REG_W   = 8;
endpackage

// File: rtl/uart_tx_status.sv
module uart_tx_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_act_i,
  input  logic tx_wr_i,
  input  logic tx_done_idle_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              busy_q <= 1'b0;
    else if (!tx_act_i)       busy_q <= 1'b0;
    else if (tx_wr_i)         busy_q <= 1'b1;  // pending data keeps it busy
    else if (tx_done_idle_i)  busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/uart_rx_guard.sv
module uart_rx_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_act_i,
  input  logic rx_frame_i,
  input  logic rx_buf_rd_i,
  output logic load_o,
  output logic ovr_set_o,
  output logic full_o
);
  logic full_q;

  // read frees the slot before the new frame is judged
  assign load_o    = rx_act_i & rx_frame_i & (~full_q | rx_buf_rd_i);
  assign ovr_set_o = rx_act_i & rx_frame_i & full_q & ~rx_buf_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          full_q <= 1'b0;
    else if (!rx_act_i)   full_q <= 1'b0;
    else if (load_o)      full_q <= 1'b1;
    else if (rx_buf_rd_i) full_q <= 1'b0;
  end

  assign full_o = full_q;
endmodule

// File: rtl/uart_err_flags.sv
module uart_err_flags #(
  parameter int N = uart_stat_pkg::N_ERR
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_act_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_q <= 1'b0;
      else if (!rx_act_i)   flag_q <= 1'b0;
      else if (set_i[i])    flag_q <= 1'b1;  // hardware set beats software clear
      else if (sw_clr_i[i]) flag_q <= 1'b0;
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags #(
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_en_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              par_chk_en_i,
  input  logic              tx_wr_i,
  input  logic              tx_done_idle_i,
  input  logic              rx_frame_i,
  input  logic              rx_par_err_i,
  input  logic              rx_stop_miss_i,
  input  logic              rx_buf_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              rx_buf_load_o,
  output logic              rx_buf_full_o
);
  import uart_stat_pkg::*;

  localparam int RSV_W = TSF_BIT - N_ERR;

  logic             tx_act, rx_act, addr_hit, wr_hit;
  logic             busy, ovr_set;
  logic [N_ERR-1:0] err_set, err_clr, err_flags;
  logic [REG_W-1:0] stat_q;
  logic             unused_wdata;

  assign tx_act   = pwr_en_i & tx_en_i;
  assign rx_act   = pwr_en_i & rx_en_i;
  assign addr_hit = (reg_addr_i == STAT_ADDR);
  assign wr_hit   = addr_hit & reg_we_i;

  uart_tx_status u_tx (
    .clk_i, .rst_ni,
    .tx_act_i       (tx_act),
    .tx_wr_i        (tx_wr_i),
    .tx_done_idle_i (tx_done_idle_i),
    .busy_o         (busy)
  );

  uart_rx_guard u_rx (
    .clk_i, .rst_ni,
    .rx_act_i    (rx_act),
    .rx_frame_i  (rx_frame_i),
    .rx_buf_rd_i (rx_buf_rd_i),
    .load_o      (rx_buf_load_o),
    .ovr_set_o   (ovr_set),
    .full_o      (rx_buf_full_o)
  );

  always_comb begin
    err_set          = '0;
    err_set[PAR_IDX] = rx_act & rx_frame_i & rx_par_err_i & par_chk_en_i;
    err_set[FRM_IDX] = rx_act & rx_frame_i & rx_stop_miss_i;
    err_set[OVR_IDX] = ovr_set;
  end

  assign err_clr      = {N_ERR{wr_hit}} & ~reg_wdata_i[N_ERR-1:0];
  assign unused_wdata = ^reg_wdata_i[7:N_ERR];

  uart_err_flags #(.N(N_ERR)) u_err (
    .clk_i, .rst_ni,
    .rx_act_i (rx_act),
    .set_i    (err_set),
    .sw_clr_i (err_clr),
    .flags_o  (err_flags)
  );

  assign stat_q      = {busy, {RSV_W{1'b0}}, err_flags};
  assign reg_rdata_o = addr_hit ? stat_q : '0;
endmodule

// File: rtl/uart_stat_flags_chk.sv
module uart_stat_flags_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_en_i,
  input logic              tx_en_i,
  input logic              rx_en_i,
  input logic              par_chk_en_i,
  input logic              tx_wr_i,
  input logic              rx_frame_i,
  input logic              rx_par_err_i,
  input logic              rx_buf_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [7:0]        reg_wdata_i,
  input logic              rx_buf_load_o,
  input logic              rx_buf_full_o,
  input logic [7:0]        stat_i
);
  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[6:3] == 4'b0);

  a_r2_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_i && tx_en_i && tx_wr_i |=> stat_i[7]);

  a_r3_busy_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_en_i && tx_en_i) |=> !stat_i[7]);

  a_r6_ovr_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_i && rx_buf_full_o && !rx_buf_rd_i |-> !rx_buf_load_o);

  a_r7_read_then_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_i && rx_en_i && rx_frame_i && rx_buf_rd_i |-> rx_buf_load_o);

  a_r8_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == STAT_ADDR && reg_wdata_i[2] && !stat_i[2]
    && !(rx_frame_i && rx_par_err_i && par_chk_en_i) |=> !stat_i[2]);

  a_r10_rx_off_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_en_i && rx_en_i) |=> stat_i[2:0] == 3'b0 && !rx_buf_full_o);

  a_r11_full_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_buf_load_o |=> rx_buf_full_o);
endmodule

bind uart_stat_flags uart_stat_flags_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_en_i(pwr_en_i), .tx_en_i(tx_en_i),
  .rx_en_i(rx_en_i), .par_chk_en_i(par_chk_en_i), .tx_wr_i(tx_wr_i),
  .rx_frame_i(rx_frame_i), .rx_par_err_i(rx_par_err_i), .rx_buf_rd_i(rx_buf_rd_i),
  .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
  .rx_buf_load_o(rx_buf_load_o), .rx_buf_full_o(rx_buf_full_o), .stat_i(stat_q)
);

// File: tb/uart_stat_flags_tb.sv
`timescale 1ns/1ps
module uart_stat_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr, txe, rxe, pchk, txw, txd, frm, perr, smiss, rd, we;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic load, full;

  int checks = 0, fails = 0, cyc = 0;
  // reference state
  bit m_busy, m_pe, m_fe, m_ov, m_full;

  always #4 clk = ~clk;

  uart_stat_flags u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr), .tx_en_i(txe), .rx_en_i(rxe),
    .par_chk_en_i(pchk), .tx_wr_i(txw), .tx_done_idle_i(txd), .rx_frame_i(frm),
    .rx_par_err_i(perr), .rx_stop_miss_i(smiss), .rx_buf_rd_i(rd),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_buf_load_o(load), .rx_buf_full_o(full)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    pwr = 1; txe = 1; rxe = 1; pchk = 1; txw = 0; txd = 0; frm = 0;
    perr = 0; smiss = 0; rd = 0; we = 0; addr = 4; wdata = 0;
  endtask

  function automatic bit m_load();
    return pwr && rxe && frm && (!m_full || rd);
  endfunction

  task automatic step(input string tag);
    bit rx_on, tx_on, ld, wr;
    @(negedge clk);
    chk({tag, " rdata"}, rdata, (addr == 4) ? {m_busy, 4'b0, m_pe, m_fe, m_ov} : 8'h00);
    chk({tag, " full"}, full, m_full);
    chk({tag, " load"}, load, m_load());
    @(posedge clk);
    rx_on = pwr && rxe; tx_on = pwr && txe;
    ld = m_load(); wr = we && addr == 4;
    if (!tx_on) m_busy = 0; else if (txw) m_busy = 1; else if (txd) m_busy = 0;
    if (!rx_on) begin m_pe = 0; m_fe = 0; m_ov = 0; m_full = 0; end
    else begin
      if (frm && perr && pchk) m_pe = 1; else if (wr && !wdata[2]) m_pe = 0;
      if (frm && smiss)        m_fe = 1; else if (wr && !wdata[1]) m_fe = 0;
      if (frm && m_full && !rd) m_ov = 1; else if (wr && !wdata[0]) m_ov = 0;
      if (ld) m_full = 1; else if (rd) m_full = 0;
    end
    #1 idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 reset", rdata, 8'h00);
    chk("R1 reset full", full, 0);
    rst_n = 1'b1;
    step("R1");
    // R2 / R3 transmit busy
    txw = 1; step("R2");
    step("R3"); txw = 1; step("R3"); step("R3");
    txd = 1; step("R3"); step("R3");
    txw = 1; txd = 1; step("R3"); step("R3");
    txe = 0; step("R3"); step("R3");
    txw = 1; pwr = 0; step("R3"); step("R3");
    // R4 parity, R5 framing
    frm = 1; perr = 1; step("R4"); step("R4");
    rd = 1; step("R7"); we = 1; wdata = 8'h00; step("R8");
    frm = 1; perr = 1; pchk = 0; step("R4"); rd = 1; step("R4");
    frm = 1; smiss = 1; step("R5"); step("R5");
    // R6 overrun, R7 read collision
    frm = 1; step("R6"); step("R6");
    frm = 1; rd = 1; step("R7"); step("R7");
    // R8 write semantics
    we = 1; wdata = 8'hFF; step("R8"); step("R8");
    we = 1; wdata = 8'h00; addr = 5; step("R8"); addr = 5; step("R8");
    we = 1; wdata = 8'hFD; step("R8"); step("R8");
    // R9 set beats clear
    frm = 1; smiss = 1; we = 1; wdata = 8'h00; step("R9"); step("R9");
    // R10 receiver / power off
    rxe = 0; frm = 1; perr = 1; smiss = 1; step("R10"); step("R10");
    frm = 1; smiss = 1; step("R10");
    pwr = 0; frm = 1; step("R10"); step("R10");
    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      int r = $urandom;
      pwr = (r[3:0] != 0); txe = (r[7:4] != 0); rxe = (r[11:8] != 0);
      pchk = r[12]; txw = r[13]; txd = r[14]; frm = r[15]; perr = r[16];
      smiss = r[17]; rd = r[18] & r[19]; we = r[20] & r[21];
      wdata = r[31:24]; addr = r[22] ? 4'd4 : r[27:24];
      step("R11");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule